// File: doc/BRIEF.md
# SAR ADC Serial Control Sequencer

This block is the digital front end of an eight-input successive-approximation converter. The host selects the chip by pulling `cs_n` low and clocks an 8-bit command in on `din`, one bit per rising `sclk` edge, most significant bit first. The command sets which channel goes to the positive side of the track/hold and what the negative side is: the common pin, or the other member of a fixed channel pair. It also carries a power-down field. The sequencer does not count leading zeros. The first 1 it sees while selected is the start bit.

All serial inputs are sampled on the block clock `clk`. Tracking begins on the falling `sclk` edge after the fifth command bit, so acquisition covers three serial cycles. The sample is taken on the falling edge after the eighth bit. At that point the sequencer emits a one-cycle sample strobe and switches the multiplexer to the negative input. It then runs a 12-step binary search on the block clock, driving trial codes to the capacitive DAC and reading back the comparator. The finished code goes into a result register together with a one-cycle done pulse, and the multiplexer returns to the positive input.

Top module: `sar_ctrl_seq`

## Requirements
- R1: After reset, `track_o`, `samp_o`, `busy_o`, `done_o` and `mux_neg_o` are 0, `result_o` is 0 and `neg_com_o` is 1.
- R2: While `cs_n` is low and no command is in progress, rising `sclk` edges with `din`=0 are ignored. The first `din`=1 is the start bit and counts as command bit 1.
- R3: `track_o` goes high one `clk` cycle after the falling `sclk` edge that follows command bit 5. It stays high until the sample is taken.
- R4: One `clk` cycle after the falling `sclk` edge that follows command bit 8, `samp_o` is high for exactly one cycle and `track_o` is low.
- R5: Command layout, MSB first: bit 7 = start, bits 6:4 = channel, bit 3 = mode (1 single-ended, 0 differential), bit 2 unused, bits 1:0 = power-down field. In single-ended mode, `pos_ch_o` equals the channel field and `neg_com_o` is 1. Both are valid from the cycle in which `track_o` rises.
- R6: In differential mode, `pos_ch_o` equals the channel field, `neg_ch_o` equals the channel field with bit 0 inverted, and `neg_com_o` is 0.
- R7: `mux_neg_o` is high from the `samp_o` cycle through the last approximation cycle, and low in the `done_o` cycle.
- R8: The approximation takes 12 `clk` cycles with `busy_o` high. The first trial code on `dac_o` is 12'h800. A trial bit is kept when `cmp_i` is 1 (trial code not above the input). `done_o` rises 13 cycles after `samp_o`, and `result_o` then holds the code found.
- R9: `done_o` is a one-cycle pulse. `result_o` changes only when `done_o` is high.
- R10: Raising `cs_n` before the sample is taken abandons the command. No `samp_o` follows, `track_o` drops on the next cycle, and the next command must start with a new start bit.
- R11: `sclk` activity during a conversion is ignored and does not start a new command.
- R12: `pd_o` takes the power-down field (command bits 1:0) when the sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial bit clock, sampled on `clk` |
| din | input | 1 | Serial command data |
| cmp_i | input | 1 | Comparator: 1 when the trial code is not above the sample |
| track_o | output | 1 | Track/hold in tracking |
| samp_o | output | 1 | One-cycle strobe at the sampling instant |
| mux_neg_o | output | 1 | Hold capacitor switched to the negative input |
| pos_ch_o | output | 3 | Positive-side channel |
| neg_ch_o | output | 3 | Negative-side channel (differential mode) |
| neg_com_o | output | 1 | Negative side is the common pin |
| pd_o | output | 2 | Power-down field of the last sampled command |
| busy_o | output | 1 | Approximation running |
| dac_o | output | 12 | Trial code to the capacitive DAC |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 12 | Last conversion result |

## Verification
Each serial edge is seen one `clk` cycle after the host drives it, because of the single `sclk` history register. The bench drives `sclk` on falling `clk` edges and samples on the following falling edge: `track_o` and the channel outputs one cycle after the bit-5 fall, `samp_o` one cycle after the bit-8 fall. The first trial code is due one cycle after `samp_o`, `busy_o` is still high eleven cycles later, and `done_o`, `result_o` and `pd_o` are checked 13 cycles after `samp_o`. One more cycle confirms the pulse has ended. The comparator in the bench is a model of an input voltage, so every expected result equals that voltage code.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORD = 2'd1,
    ST_ACQ  = 2'd2,
    ST_CONV = 2'd3
  } seq_state_t;

  // command field positions in the full 8-bit word (MSB first on the wire)
  localparam int unsigned CH_HI   = 6;
  localparam int unsigned CH_LO   = 4;
  localparam int unsigned SE_POS  = 3;
  localparam int unsigned PD_HI   = 1;
  localparam int unsigned PD_LO   = 0;
endpackage

// File: rtl/sar_word_rx.sv
module sar_word_rx
  import sar_seq_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8,
  parameter int unsigned TRACK_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 din,
  input  logic                 conv_done,
  output logic                 track,
  output logic                 track_go,
  output logic                 hold_go,
  output logic [WORD_BITS-1:0] word
);
  localparam int unsigned CW = $clog2(WORD_BITS + 1);

  seq_state_t           state, state_d;
  logic [CW-1:0]        cnt, cnt_d;
  logic [WORD_BITS-1:0] sreg, sreg_d;
  logic                 sclk_q;
  logic                 rise, fall, sel;

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
  assign sel  = ~cs_n;

  always_comb begin
    state_d  = state;
    cnt_d    = cnt;
    sreg_d   = sreg;
    track_go = 1'b0;
    hold_go  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sel && rise && din) begin
          state_d = ST_WORD;
          cnt_d   = CW'(1);
          sreg_d  = WORD_BITS'(1);
        end
      end
      ST_WORD: begin
        if (!sel) begin
          state_d = ST_IDLE;
        end else begin
          if (rise) begin
            sreg_d = {sreg[WORD_BITS-2:0], din};
            cnt_d  = cnt + CW'(1);
          end
          if (fall && (cnt == CW'(TRACK_BIT))) begin
            state_d  = ST_ACQ;
            track_go = 1'b1;
          end
        end
      end
      ST_ACQ: begin
        if (!sel) begin
          state_d = ST_IDLE;
        end else begin
          if (rise) begin
            sreg_d = {sreg[WORD_BITS-2:0], din};
            cnt_d  = cnt + CW'(1);
          end
          if (fall && (cnt == CW'(WORD_BITS))) begin
            state_d = ST_CONV;
            hold_go = 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (conv_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sreg   <= '0;
      sclk_q <= 1'b0;
    end else begin
      state  <= state_d;
      cnt    <= cnt_d;
      sreg   <= sreg_d;
      sclk_q <= sclk;
    end
  end

  assign track = (state == ST_ACQ);
  assign word  = sreg;
endmodule

// File: rtl/sar_chan_decode.sv
module sar_chan_decode #(
  parameter int unsigned CH_BITS = 3
) (
  input  logic [CH_BITS-1:0] chan,
  input  logic               single,
  output logic [CH_BITS-1:0] pos,
  output logic [CH_BITS-1:0] neg,
  output logic               neg_com
);
  // pairs are adjacent channels differing only in bit 0
  always_comb begin
    pos     = chan;
    neg_com = single;
    neg     = single ? '0 : {chan[CH_BITS-1:1], ~chan[0]};
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmp,
  output logic                busy,
  output logic [RES_BITS-1:0] dac,
  output logic                done,
  output logic [RES_BITS-1:0] result
);
  localparam int unsigned IW = $clog2(RES_BITS);

  logic [IW-1:0]       idx, idx_d;
  logic [RES_BITS-1:0] work, work_d, result_d, trial;
  logic                busy_d, done_d;

  assign trial = RES_BITS'(1) << idx;
  assign dac   = busy ? (work | trial) : '0;

  always_comb begin
    idx_d    = idx;
    work_d   = work;
    busy_d   = busy;
    result_d = result;
    done_d   = 1'b0;
    if (!busy) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = IW'(RES_BITS - 1);
        work_d = '0;
      end
    end else begin
      if (cmp) work_d = work | trial;
      if (idx == '0) begin
        busy_d   = 1'b0;
        done_d   = 1'b1;
        result_d = cmp ? (work | trial) : work;
      end else begin
        idx_d = idx - IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      work   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      idx  <= idx_d;
      work <= work_d;
      busy <= busy_d;
      done <= done_d;
      if (done_d) result <= result_d;
    end
  end
endmodule

// File: rtl/sar_ctrl_seq.sv
module sar_ctrl_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8,
  parameter int unsigned TRACK_BIT = 5,
  parameter int unsigned CH_BITS   = 3,
  parameter int unsigned PD_BITS   = 2,
  parameter int unsigned RES_BITS  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                din,
  input  logic                cmp_i,
  output logic                track_o,
  output logic                samp_o,
  output logic                mux_neg_o,
  output logic [CH_BITS-1:0]  pos_ch_o,
  output logic [CH_BITS-1:0]  neg_ch_o,
  output logic                neg_com_o,
  output logic [PD_BITS-1:0]  pd_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] dac_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o
);
  // bits still to arrive when tracking starts; fields sit lower by this much
  localparam int unsigned LAG = WORD_BITS - TRACK_BIT;

  logic                 track_go, hold_go, track;
  logic [WORD_BITS-1:0] word, early;
  logic [CH_BITS-1:0]   pos_d, neg_d;
  logic                 com_d;

  sar_word_rx #(.WORD_BITS(WORD_BITS), .TRACK_BIT(TRACK_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_done(done_o), .track(track), .track_go(track_go),
    .hold_go(hold_go), .word(word)
  );

  assign early = word << LAG;

  sar_chan_decode #(.CH_BITS(CH_BITS)) u_dec (
    .chan(early[CH_HI:CH_LO]), .single(early[SE_POS]),
    .pos(pos_d), .neg(neg_d), .neg_com(com_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_o    <= 1'b0;
      pos_ch_o  <= '0;
      neg_ch_o  <= '0;
      neg_com_o <= 1'b1;
      pd_o      <= '0;
    end else begin
      samp_o <= hold_go;
      if (track_go) begin
        pos_ch_o  <= pos_d;
        neg_ch_o  <= neg_d;
        neg_com_o <= com_d;
      end
      if (hold_go) pd_o <= word[PD_HI:PD_LO];
    end
  end

  sar_approx #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(samp_o), .cmp(cmp_i),
    .busy(busy_o), .dac(dac_o), .done(done_o), .result(result_o)
  );

  assign track_o   = track;
  assign mux_neg_o = samp_o | busy_o;
endmodule

// File: rtl/sar_ctrl_seq_chk.sv
module sar_ctrl_seq_chk #(
  parameter int unsigned CH_BITS  = 3,
  parameter int unsigned RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                track_o,
  input logic                samp_o,
  input logic                mux_neg_o,
  input logic [CH_BITS-1:0]  pos_ch_o,
  input logic [CH_BITS-1:0]  neg_ch_o,
  input logic                neg_com_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [RES_BITS-1:0] result_o
);
  p_samp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |=> !samp_o);
  p_samp_ends_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |-> (!track_o && $past(track_o)));
  p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (track_o && !neg_com_o) |-> (neg_ch_o == (pos_ch_o ^ CH_BITS'(1))));
  p_mux_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |-> mux_neg_o);
  p_mux_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mux_neg_o);
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
  p_abort_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !track_o);
  p_abort_samp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !samp_o);
endmodule

bind sar_ctrl_seq sar_ctrl_seq_chk #(.CH_BITS(CH_BITS), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .track_o(track_o), .samp_o(samp_o),
  .mux_neg_o(mux_neg_o), .pos_ch_o(pos_ch_o), .neg_ch_o(neg_ch_o),
  .neg_com_o(neg_com_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/sim_sar_ctrl_seq.sv
`timescale 1ns/1ps
module sim_sar_ctrl_seq;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din, cmp;
  logic        track_o, samp_o, mux_neg_o, neg_com_o, busy_o, done_o;
  logic [2:0]  pos_ch_o, neg_ch_o;
  logic [1:0]  pd_o;
  logic [11:0] dac_o, result_o;
  logic [11:0] vin;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  assign cmp = (dac_o <= vin);

  sar_ctrl_seq u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_i(cmp),
    .track_o(track_o), .samp_o(samp_o), .mux_neg_o(mux_neg_o),
    .pos_ch_o(pos_ch_o), .neg_ch_o(neg_ch_o), .neg_com_o(neg_com_o),
    .pd_o(pd_o), .busy_o(busy_o), .dac_o(dac_o), .done_o(done_o),
    .result_o(result_o)
  );

  // {lead zeros[21:20], command[19:12], input code[11:0]}
  localparam logic [21:0] VEC [0:5] = '{
    22'h089ABC, 22'h2DA000, 22'h1A3FFF, 22'h0B0555, 22'h3F5800, 22'h0E87FF
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b);
    @(negedge clk) din = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  // sends the command; checks tracking and channel decode after bit 5
  task automatic send_word(input logic [7:0] w, input int lead);
    for (int i = 0; i < lead; i++) clock_bit(1'b0);
    for (int i = 7; i >= 0; i--) begin
      clock_bit(w[i]);
      if (i == 3) begin
        chk("R3 track low before edge seen", track_o, 0);
        @(negedge clk);
        chk("R2 R3 track high after bit5", track_o, 1);
        chk("R5 R6 positive channel", pos_ch_o, w[6:4]);
        chk("R5 R6 common flag", neg_com_o, w[3]);
        if (!w[3]) chk("R6 pair member", neg_ch_o, {w[6:5], ~w[4]});
      end
    end
    chk("R3 track held to hold edge", track_o, 1);
  endtask

  task automatic run_conv(input logic [11:0] exp_res, input logic [1:0] exp_pd);
    @(negedge clk);
    chk("R4 samp strobe", samp_o, 1);
    chk("R4 track ends", track_o, 0);
    chk("R7 mux to negative", mux_neg_o, 1);
    @(negedge clk);
    chk("R8 first trial", dac_o, 12'h800);
    chk("R8 busy", busy_o, 1);
    chk("R4 samp one cycle", samp_o, 0);
    repeat (11) @(negedge clk);
    chk("R8 busy last step", busy_o, 1);
    chk("R8 no early done", done_o, 0);
    chk("R7 mux during conv", mux_neg_o, 1);
    @(negedge clk);
    chk("R8 done", done_o, 1);
    chk("R8 result", result_o, exp_res);
    chk("R12 power-down field", pd_o, exp_pd);
    chk("R7 mux back", mux_neg_o, 0);
    @(negedge clk);
    chk("R9 done one cycle", done_o, 0);
    chk("R9 result kept", result_o, exp_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 track", track_o, 0);
    chk("R1 samp", samp_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 mux", mux_neg_o, 0);
    chk("R1 result", result_o, 0);
    chk("R1 common", neg_com_o, 1);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] w;
      w   = VEC[v][19:12];
      vin = VEC[v][11:0];
      cs_n = 1'b0;
      send_word(w, int'(VEC[v][21:20]));
      run_conv(VEC[v][11:0], w[1:0]);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R10: abort during the command, before tracking
    cs_n = 1'b0;
    clock_bit(1'b1); clock_bit(1'b1); clock_bit(1'b0);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    clock_bit(1'b0); clock_bit(1'b0);
    @(negedge clk);
    chk("R10 R2 no track after abort", track_o, 0);

    // R10: abort during acquisition
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b1);
    @(negedge clk);
    chk("R10 tracking before abort", track_o, 1);
    clock_bit(1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R10 track dropped", track_o, 0);
    cs_n = 1'b0;
    clock_bit(1'b0); clock_bit(1'b0);
    @(negedge clk);
    chk("R10 no samp", samp_o, 0);
    chk("R10 no track", track_o, 0);
    chk("R10 mux stays", mux_neg_o, 0);
    chk("R10 result untouched", result_o, 12'h7FF);

    // R11: serial edges during conversion ignored
    vin = 12'h3C5;
    send_word(8'hC8, 0);
    @(negedge clk);
    chk("R4 samp", samp_o, 1);
    din = 1'b1;
    @(negedge clk) sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 done", done_o, 1);
    chk("R11 result", result_o, 12'h3C5);
    for (int k = 0; k < 4; k++) clock_bit(1'b0);
    @(negedge clk);
    chk("R11 no command started", track_o, 0);

    // R9: result steady while input moves
    vin = 12'h001;
    repeat (20) @(negedge clk);
    chk("R9 result steady", result_o, 12'h3C5);
    chk("R9 no done", done_o, 0);

    cs_n = 1'b1;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule